// File: doc/BRIEF.md
# E1 Transmit Frame Sync Generator

This block produces the timing for the transmit side of a 2.048 Mbit/s E1 serial link. A free-running position counter marks the current bit of the 256-bit frame, which holds 32 timeslots of 8 bits, and the current frame of a 16-frame multiframe. From that position the block drives four things:

- a bit-rate enable;
- a frame pulse on the first bit of every frame;
- a multiframe pulse whose spacing and polarity are configurable;
- a serial data stream.

The serial stream is shifted out of a byte-wide payload input. A load strobe tells the payload source when to present the next byte.

The system clock runs `DIV` times faster than the line bit rate, and one bit period lasts `DIV` clocks. In structured operation the multiframe pulse marks either every second frame (double-frame spacing, 250 µs) or every sixteenth frame (CRC multiframe spacing, 2 ms). In unstructured operation it stays at its inactive level.

The mode and polarity inputs are captured only at 16-frame boundaries. The pulse pattern therefore never changes partway through a multiframe.

Top module: `e1_tx_sync`

## Requirements
- R1: `bit_tick` is high on the first clock of each bit period and low on the other `DIV-1` clocks. `bit_pos` gives the bit index within the frame, 0 to 255, and advances by one per bit period, wrapping from 255 to 0.
- R2: `frame_pulse` is high, active high, for the whole bit period of bit 0 of timeslot 0 of every frame, and low at all other times.
- R3: With structured mode selected (`cfg_structured`=1) and CRC multiframe spacing selected (`cfg_crc_mf`=1), the multiframe pulse is active during bit 0 of frame 0 of each 16-frame multiframe only. That is 2 active bit periods in 32 frames.
- R4: With structured mode and double-frame spacing selected (`cfg_crc_mf`=0), the multiframe pulse is active during bit 0 of every even-numbered frame. That is 8 active bit periods per 16 frames.
- R5: In unstructured mode (`cfg_structured`=0), the multiframe pulse stays at its inactive level at all times.
- R6: `cfg_mf_high`=1 makes the multiframe pulse active high (idle 0). `cfg_mf_high`=0 makes it active low (idle 1).
- R7: The multiframe pulse is active for exactly one bit period, and only while `frame_pulse` is high.
- R8: A change of `cfg_structured`, `cfg_crc_mf` or `cfg_mf_high` takes effect on the first bit of the next 16-frame multiframe. Until then the previous setting governs the multiframe pulse.
- R9: `byte_load` is high for the whole bit period of bit B8 (bit 7 within the slot) of every timeslot. `tx_byte` is sampled on the last clock of that period and becomes the byte of the following timeslot.
- R10: `tx_data` sends each loaded byte most significant bit (B1) first, one bit per bit period, and is stable within a bit period.
- R11: A synchronous reset (`rst`=1) sets the position to bit 0 of frame 0 and clears the serial shift register, so the first timeslot after reset sends zeros. It also captures the configuration inputs directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, DIV clocks per line bit |
| rst | input | 1 | Synchronous reset, active high |
| cfg_structured | input | 1 | 1 = structured, 0 = unstructured |
| cfg_crc_mf | input | 1 | 1 = 16-frame spacing, 0 = 2-frame spacing |
| cfg_mf_high | input | 1 | Multiframe pulse polarity, 1 = active high |
| tx_byte | input | 8 | Payload byte for the next timeslot |
| bit_tick | output | 1 | High on the first clock of each bit period |
| bit_pos | output | 8 | Bit index within the frame |
| byte_load | output | 1 | Request for the next payload byte |
| tx_data | output | 1 | Serial transmit data |
| frame_pulse | output | 1 | Frame start marker |
| mf_pulse | output | 1 | Multiframe start marker |

## Verification
The bench keeps its own model of the line position and goes after the points where a timing generator usually slips.

- **Configuration capture.** The configuration is changed halfway through a multiframe. A design that applied it at once would show extra or missing multiframe pulses before the boundary.
- **Spacing, polarity and unstructured idle.** All three are swept. A swapped spacing rule or an inverted idle level shows up directly in the count of active bit periods per multiframe.
- **Serial data path.** Every transmitted bit is compared against a per-slot pattern. A load taken one bit late, or a byte shifted out LSB first, corrupts whole slots.
- **Reset.** A reset is applied mid-frame, after which the bench expects position zero and an all-zero first timeslot.

// File: rtl/e1_tx_sync.sv
module e1_tx_sync #(
  parameter int DIV       = 1,
  parameter int SLOTS     = 32,
  parameter int MF_FRAMES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_structured,
  input  logic       cfg_crc_mf,
  input  logic       cfg_mf_high,
  input  logic [7:0] tx_byte,
  output logic       bit_tick,
  output logic [$clog2(SLOTS*8)-1:0] bit_pos,
  output logic       byte_load,
  output logic       tx_data,
  output logic       frame_pulse,
  output logic       mf_pulse
);
  localparam int FRAME_BITS = SLOTS * 8;
  localparam int BW = $clog2(FRAME_BITS);
  localparam int FW = (MF_FRAMES > 1) ? $clog2(MF_FRAMES) : 1;
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_cnt;
  logic [BW-1:0] bit_cnt;
  logic [FW-1:0] frm_cnt;
  logic [7:0]    sh;
  logic          act_s, act_c, act_p;

  logic adv, bit_last, frm_last, mf_end, mf_act;

  assign adv      = (div_cnt == DW'(DIV - 1));
  assign bit_last = (bit_cnt == BW'(FRAME_BITS - 1));
  assign frm_last = (frm_cnt == FW'(MF_FRAMES - 1));
  assign mf_end   = adv && bit_last && frm_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bit_cnt <= '0;
      frm_cnt <= '0;
    end else if (adv) begin
      div_cnt <= '0;
      bit_cnt <= bit_last ? '0 : bit_cnt + BW'(1);
      if (bit_last) frm_cnt <= frm_last ? '0 : frm_cnt + FW'(1);
    end else begin
      div_cnt <= div_cnt + DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      sh <= '0;
    else if (adv)
      sh <= (bit_cnt[2:0] == 3'd7) ? tx_byte : {sh[6:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst || mf_end) begin
      act_s <= cfg_structured;
      act_c <= cfg_crc_mf;
      act_p <= cfg_mf_high;
    end
  end

  assign mf_act      = act_s && (bit_cnt == '0) &&
                       (act_c ? (frm_cnt == '0) : !frm_cnt[0]);
  assign bit_tick    = (div_cnt == '0);
  assign bit_pos     = bit_cnt;
  assign byte_load   = (bit_cnt[2:0] == 3'd7);
  assign tx_data     = sh[7];
  assign frame_pulse = (bit_cnt == '0);
  assign mf_pulse    = act_p ? mf_act : !mf_act;

  a_r1_bit_step: assert property (@(posedge clk) disable iff (rst)
    adv |=> bit_cnt == ($past(bit_last) ? '0 : $past(bit_cnt) + BW'(1)));
  a_r1_bit_hold: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(bit_cnt));
  a_r3_frame_step: assert property (@(posedge clk) disable iff (rst)
    (adv && bit_last) |=> frm_cnt == ($past(frm_last) ? '0 : $past(frm_cnt) + FW'(1)));
  a_r7_mf_in_frame: assert property (@(posedge clk) disable iff (rst)
    mf_act |-> frame_pulse);
  a_r8_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !mf_end |=> $stable({act_s, act_c, act_p}));
  a_r10_data_steady: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(tx_data));
endmodule

// File: tb/e1_tx_sync_test.sv
module e1_tx_sync_test;
  localparam int DIV = 2;
  localparam int MF  = DIV * 256 * 16;
  localparam logic [6:0] VEC [0:4] = '{
    {1'b1, 1'b1, 1'b1, 4'd1},
    {1'b1, 1'b0, 1'b1, 4'd8},
    {1'b1, 1'b0, 1'b0, 4'd8},
    {1'b0, 1'b1, 1'b1, 4'd0},
    {1'b1, 1'b1, 1'b0, 4'd1}
  };

  logic clk = 0, rst = 1;
  logic cfg_s = 1, cfg_c = 1, cfg_p = 1;
  logic [7:0] tx_byte;
  logic bit_tick, byte_load, tx_data, frame_pulse, mf_pulse;
  logic [7:0] bit_pos;

  int n = 0, checks = 0, failures = 0;
  logic app_s, app_c, app_p;
  logic mon = 0, done = 0;
  int e_tick = 0, e_pos = 0, e_fp = 0, e_load = 0, e_data = 0, e_mf = 0, e_r7 = 0;
  int mf_cnt = 0, shown = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + 11);
  endfunction

  assign tx_byte = pat((n / DIV) / 8 + 1);

  e1_tx_sync #(.DIV(DIV)) uut (
    .clk(clk), .rst(rst), .cfg_structured(cfg_s), .cfg_crc_mf(cfg_c),
    .cfg_mf_high(cfg_p), .tx_byte(tx_byte), .bit_tick(bit_tick),
    .bit_pos(bit_pos), .byte_load(byte_load), .tx_data(tx_data),
    .frame_pulse(frame_pulse), .mf_pulse(mf_pulse));

  always @(posedge clk) begin
    n <= rst ? 0 : n + 1;
    if (rst || (n % MF == MF - 1)) begin
      app_s <= cfg_s; app_c <= cfg_c; app_p <= cfg_p;
    end
  end

  int bi, sl, bb, fi;
  logic ex_fp, ex_act, ex_mf, ex_tx;
  always @(negedge clk) if (!rst && mon) begin
    bi = n / DIV; sl = bi / 8; bb = bi % 8; fi = (bi / 256) % 16;
    ex_fp  = (bi % 256 == 0);
    ex_act = app_s && ex_fp && (app_c ? fi == 0 : fi % 2 == 0);
    ex_mf  = app_p ? ex_act : !ex_act;
    ex_tx  = (sl == 0) ? 1'b0 : pat(sl)[7 - bb];
    if (bit_tick !== (n % DIV == 0)) e_tick++;
    if (bit_pos !== 8'(bi % 256)) e_pos++;
    if (frame_pulse !== ex_fp) e_fp++;
    if (byte_load !== (bb == 7)) e_load++;
    if (tx_data !== ex_tx) e_data++;
    if (mf_pulse !== ex_mf) begin
      e_mf++;
      if (shown < 5) begin
        shown++;
        $display("mismatch n=%0d mf_pulse=%0b exp=%0b", n, mf_pulse, ex_mf);
      end
    end
    if (bit_tick && mf_pulse === app_p) mf_cnt++;
    if (mf_pulse === app_p && !frame_pulse) e_r7++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) step();
    @(negedge clk);
    chk("R11 bit_pos at reset", bit_pos, 0);
    chk("R11 tx_data at reset", tx_data, 0);
    chk("R11 frame_pulse at reset", frame_pulse, 1);
    chk("R11 mf_pulse at reset", mf_pulse, 1);
    step();
    rst = 0; mon = 1;
    for (int v = 0; v < 5; v++) begin
      string tag;
      while (n % MF != MF / 2) step();
      {cfg_s, cfg_c, cfg_p} = VEC[v][6:4];
      e_mf = 0;
      while (n % MF != 0) step();
      chk("R8 old setting until boundary", e_mf, 0);
      e_mf = 0; mf_cnt = 0;
      step();
      while (n % MF != 0) step();
      tag = !VEC[v][6] ? "R5" : (VEC[v][5] ? "R3" : "R4");
      chk({tag, " multiframe pulse pattern"}, e_mf, 0);
      chk({tag, " R6 active periods per multiframe"}, mf_cnt, int'(VEC[v][3:0]));
    end
    while (n % MF != 1003) step();
    rst = 1; cfg_s = 0; cfg_p = 0;
    step(); step();
    @(negedge clk);
    chk("R11 bit_pos after mid-run reset", bit_pos, 0);
    chk("R11 frame_pulse after mid-run reset", frame_pulse, 1);
    chk("R11 R5 captured unstructured idle", mf_pulse, 1);
    step();
    rst = 0; e_mf = 0; mf_cnt = 0;
    repeat (3 * 256 * DIV) step();
    chk("R5 idle after reset capture", e_mf + mf_cnt, 0);
    chk("R1 bit_tick spacing", e_tick, 0);
    chk("R1 bit_pos count", e_pos, 0);
    chk("R2 frame_pulse", e_fp, 0);
    chk("R7 mf only within frame pulse", e_r7, 0);
    chk("R9 byte_load timing", e_load, 0);
    chk("R10 R11 serial data", e_data, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule